// File: doc/BRIEF.md
# Scratchpad memory with atomic operations

A shared on-chip scratch store of 4096 words of 32 bits, served by one command port. A command carries an opcode, a word address, a burst length and an ID. Plain reads and writes move between 1 and 16 consecutive words. Seven atomic read-modify-write operations act on a single word. The operations are bit-set, bit-clear, increment, decrement, add, subtract and swap. Each atomic can optionally hand back the value the word held before the change.

Write data and atomic operands reach the unit through a pull interface. The unit raises a request tagged with the command ID, and the source answers with a valid strobe whenever it has data. Read results and returned old values leave through a push interface, one word per cycle, tagged with the ID and marked on the final word. Nothing is byte-addressable. Every store replaces a full 32-bit word.

The unit takes one command at a time. It holds the command input off while a read-modify-write is open, so no other command can touch the word between the fetch and the write-back.

Top module: `spm_top`

## Requirements
- R1: After reset, cmd_ready is high and push_valid and pull_req are low.
- R2: Opcode 0 (read) with length field L (0..15) returns L+1 words from consecutive addresses. They come out in address order on consecutive cycles, all carrying the command's ID, with push_last set only on the final word.
- R3: Opcode 1 (write) with length field L pulls L+1 words and stores each as a whole 32-bit word at consecutive addresses. It pushes nothing.
- R4: A read or write burst that runs past the highest word address continues at word 0.
- R5: Opcode 2 (bit-set) ORs the pulled operand into the word. Opcode 3 (bit-clear) ANDs the complement of the pulled operand into the word.
- R6: Opcode 4 (increment) and opcode 5 (decrement) add or subtract 1 modulo 2^32 and pull no operand.
- R7: Opcode 6 (add) and opcode 7 (subtract) combine the word with the pulled operand modulo 2^32.
- R8: Opcode 8 (swap) stores the pulled operand in the word.
- R9: An atomic command with cmd_ret set pushes exactly one word: the pre-change value, with the command's ID and push_last set. An atomic command with cmd_ret clear pushes nothing.
- R10: From the acceptance of an atomic command until its write-back, cmd_ready stays low. A command that follows it sees the updated word.
- R11: An atomic command changes only the addressed word, whatever its length field holds.
- R12: Opcodes 9 to 15 are accepted and discarded. They cause no pull, no push and no change to memory.
- R13: pull_req is high only while the unit waits for write data or an atomic operand, and it carries the command's ID. The unit waits any number of cycles for pull_valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Unit can take a command this cycle |
| cmd_op | input | 4 | Opcode |
| cmd_addr | input | ADDR_W | Starting word address |
| cmd_len | input | 4 | Burst length minus one |
| cmd_ret | input | 1 | Atomic: return the pre-change value |
| cmd_id | input | ID_W | Command tag |
| pull_req | output | 1 | Unit wants one word of write data or operand |
| pull_id | output | ID_W | Tag of the command requesting data |
| pull_valid | input | 1 | pull_data is valid and taken this cycle |
| pull_data | input | 32 | Write data or operand |
| push_valid | output | 1 | Result word present |
| push_data | output | 32 | Read data or pre-change value |
| push_id | output | ID_W | Tag of the command the word belongs to |
| push_last | output | 1 | Final word of the command's response |

## Verification
The bench builds the unit with ADDR_W = 6, a 64-word store, and ID_W = 4. The small store lets random bursts cross the top of the address space often, which exercises the wrap-around. It also makes random atomics land repeatedly on words that earlier commands wrote. The 4-bit ID wraps every sixteen commands, so tags are reused while earlier traffic may still be draining. The pull source withholds data at random, which stretches both write bursts and atomic operand waits.

// File: rtl/spm_pkg.sv
package spm_pkg;

  localparam int DATA_W = 32;

  typedef enum logic [3:0] {
    OP_READ  = 4'd0,
    OP_WRITE = 4'd1,
    OP_BSET  = 4'd2,
    OP_BCLR  = 4'd3,
    OP_INC   = 4'd4,
    OP_DEC   = 4'd5,
    OP_ADD   = 4'd6,
    OP_SUB   = 4'd7,
    OP_SWAP  = 4'd8
  } spm_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WRITE,
    ST_AFETCH,
    ST_AMOD
  } spm_state_e;

  function automatic logic op_is_atomic(input logic [3:0] op);
    return (op >= OP_BSET) && (op <= OP_SWAP);
  endfunction

  function automatic logic op_needs_operand(input logic [3:0] op);
    return op_is_atomic(op) && (op != OP_INC) && (op != OP_DEC);
  endfunction

  function automatic logic [DATA_W-1:0] atomic_result(
      input logic [3:0]        op,
      input logic [DATA_W-1:0] cur,
      input logic [DATA_W-1:0] opnd);
    logic [DATA_W-1:0] res;
    case (op)
      OP_BSET: res = cur | opnd;
      OP_BCLR: res = cur & ~opnd;
      OP_INC:  res = cur + DATA_W'(1);
      OP_DEC:  res = cur - DATA_W'(1);
      OP_ADD:  res = cur + opnd;
      OP_SUB:  res = cur - opnd;
      OP_SWAP: res = opnd;
      default: res = cur;
    endcase
    return res;
  endfunction

endpackage

// File: rtl/spm_mem.sv
module spm_mem #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= store[raddr];
  end

endmodule

// File: rtl/spm_seq.sv
module spm_seq
  import spm_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int ID_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [3:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [3:0]        cmd_len,
  input  logic              cmd_ret,
  input  logic [ID_W-1:0]   cmd_id,
  output logic              pull_req,
  output logic [ID_W-1:0]   pull_id,
  input  logic              pull_valid,
  input  logic [DATA_W-1:0] pull_data,
  input  logic [DATA_W-1:0] mem_q,
  output logic              mem_re,
  output logic [ADDR_W-1:0] mem_raddr,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              rd_issue,
  output logic              rd_last,
  output logic [ID_W-1:0]   rd_id,
  output logic              ao_push,
  output logic              at_wb
);
  spm_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic [3:0]        cnt_q;
  logic [ID_W-1:0]   id_q;
  logic [3:0]        op_q;
  logic              ret_q;

  logic accept;
  logic beat;
  logic last_beat;

  assign cmd_ready = (state_q == ST_IDLE);
  assign accept    = cmd_valid && cmd_ready;
  assign last_beat = (cnt_q == 4'd0);
  assign pull_id   = id_q;
  assign rd_id     = id_q;
  assign mem_raddr = addr_q;
  assign mem_waddr = addr_q;

  always_comb begin
    state_d   = state_q;
    mem_re    = 1'b0;
    mem_we    = 1'b0;
    mem_wdata = pull_data;
    pull_req  = 1'b0;
    rd_issue  = 1'b0;
    rd_last   = 1'b0;
    ao_push   = 1'b0;
    at_wb     = 1'b0;
    beat      = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          if (cmd_op == OP_READ)          state_d = ST_READ;
          else if (cmd_op == OP_WRITE)    state_d = ST_WRITE;
          else if (op_is_atomic(cmd_op))  state_d = ST_AFETCH;
        end
      end
      ST_READ: begin
        mem_re   = 1'b1;
        rd_issue = 1'b1;
        rd_last  = last_beat;
        beat     = 1'b1;
        if (last_beat) state_d = ST_IDLE;
      end
      ST_WRITE: begin
        pull_req = 1'b1;
        if (pull_valid) begin
          mem_we = 1'b1;
          beat   = 1'b1;
          if (last_beat) state_d = ST_IDLE;
        end
      end
      ST_AFETCH: begin
        mem_re  = 1'b1;
        state_d = ST_AMOD;
      end
      ST_AMOD: begin
        mem_re    = 1'b1;
        pull_req  = op_needs_operand(op_q);
        at_wb     = !op_needs_operand(op_q) || pull_valid;
        mem_we    = at_wb;
        mem_wdata = atomic_result(op_q, mem_q, pull_data);
        ao_push   = at_wb && ret_q;
        if (at_wb) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      cnt_q   <= '0;
      id_q    <= '0;
      op_q    <= '0;
      ret_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        addr_q <= cmd_addr;
        cnt_q  <= cmd_len;
        id_q   <= cmd_id;
        op_q   <= cmd_op;
        ret_q  <= cmd_ret;
      end else if (beat) begin
        addr_q <= addr_q + ADDR_W'(1);
        cnt_q  <= cnt_q - 4'd1;
      end
    end
  end

endmodule

// File: rtl/spm_push.sv
module spm_push
  import spm_pkg::*;
#(
  parameter int ID_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_issue,
  input  logic              rd_last,
  input  logic [ID_W-1:0]   rd_id,
  input  logic              ao_push,
  input  logic [DATA_W-1:0] mem_q,
  output logic              push_valid,
  output logic [DATA_W-1:0] push_data,
  output logic [ID_W-1:0]   push_id,
  output logic              push_last
);
  logic            s1_vld;
  logic            s1_last;
  logic [ID_W-1:0] s1_id;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld     <= 1'b0;
      s1_last    <= 1'b0;
      s1_id      <= '0;
      push_valid <= 1'b0;
      push_data  <= '0;
      push_id    <= '0;
      push_last  <= 1'b0;
    end else begin
      s1_vld     <= rd_issue;
      s1_last    <= rd_last;
      s1_id      <= rd_id;
      push_valid <= s1_vld || ao_push;
      push_data  <= mem_q;
      push_id    <= s1_vld ? s1_id : rd_id;
      push_last  <= s1_vld ? s1_last : ao_push;
    end
  end

endmodule

// File: rtl/spm_top.sv
module spm_top
  import spm_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int ID_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [3:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [3:0]        cmd_len,
  input  logic              cmd_ret,
  input  logic [ID_W-1:0]   cmd_id,
  output logic              pull_req,
  output logic [ID_W-1:0]   pull_id,
  input  logic              pull_valid,
  input  logic [31:0]       pull_data,
  output logic              push_valid,
  output logic [31:0]       push_data,
  output logic [ID_W-1:0]   push_id,
  output logic              push_last
);
  logic              mem_re;
  logic [ADDR_W-1:0] mem_raddr;
  logic [DATA_W-1:0] mem_q;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_waddr;
  logic [DATA_W-1:0] mem_wdata;
  logic              rd_issue;
  logic              rd_last;
  logic [ID_W-1:0]   rd_id;
  logic              ao_push;
  logic              at_wb;

  spm_seq #(.ADDR_W(ADDR_W), .ID_W(ID_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_ret(cmd_ret), .cmd_id(cmd_id),
    .pull_req(pull_req), .pull_id(pull_id), .pull_valid(pull_valid),
    .pull_data(pull_data), .mem_q(mem_q),
    .mem_re(mem_re), .mem_raddr(mem_raddr),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .rd_issue(rd_issue), .rd_last(rd_last), .rd_id(rd_id),
    .ao_push(ao_push), .at_wb(at_wb)
  );

  spm_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk(clk), .re(mem_re), .raddr(mem_raddr), .rdata(mem_q),
    .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata)
  );

  spm_push #(.ID_W(ID_W)) u_push (
    .clk(clk), .rst_n(rst_n),
    .rd_issue(rd_issue), .rd_last(rd_last), .rd_id(rd_id),
    .ao_push(ao_push), .mem_q(mem_q),
    .push_valid(push_valid), .push_data(push_data),
    .push_id(push_id), .push_last(push_last)
  );

endmodule

// File: rtl/spm_chk.sv
module spm_chk
  import spm_pkg::*;
#(
  parameter int ID_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cmd_valid,
  input logic            cmd_ready,
  input logic [3:0]      cmd_op,
  input logic            pull_req,
  input logic            pull_valid,
  input logic            push_valid,
  input logic            push_last,
  input logic [ID_W-1:0] push_id,
  input logic            mem_we,
  input logic            at_wb
);
  // R10
  atomic_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && op_is_atomic(cmd_op)) |=> !cmd_ready);

  // R13
  pull_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !pull_req);

  // R2
  push_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_last |-> push_valid);

  // R2
  burst_gapless_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && !push_last) |=> (push_valid && $stable(push_id)));

  // R3
  write_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ((pull_req && pull_valid) || at_wb));

  // R12
  reserved_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && (cmd_op > OP_SWAP)) |=> (cmd_ready && !pull_req));

endmodule

bind spm_top spm_chk #(.ID_W(ID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_op), .pull_req(pull_req), .pull_valid(pull_valid),
  .push_valid(push_valid), .push_last(push_last), .push_id(push_id),
  .mem_we(mem_we), .at_wb(at_wb)
);

// File: tb/spm_top_tb.sv
`timescale 1ns/1ps
module spm_top_tb;
  localparam int AW    = 6;
  localparam int IW    = 4;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [3:0]    cmd_op = '0;
  logic [AW-1:0] cmd_addr = '0;
  logic [3:0]    cmd_len = '0;
  logic          cmd_ret = 1'b0;
  logic [IW-1:0] cmd_id = '0;
  logic          pull_req;
  logic [IW-1:0] pull_id;
  logic          pull_valid = 1'b0;
  logic [31:0]   pull_data = '0;
  logic          push_valid;
  logic [31:0]   push_data;
  logic [IW-1:0] push_id;
  logic          push_last;

  always #10 clk = ~clk;

  spm_top #(.ADDR_W(AW), .ID_W(IW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_ret(cmd_ret),
    .cmd_id(cmd_id), .pull_req(pull_req), .pull_id(pull_id),
    .pull_valid(pull_valid), .pull_data(pull_data), .push_valid(push_valid),
    .push_data(push_data), .push_id(push_id), .push_last(push_last)
  );

  logic [31:0]   ref_mem [DEPTH];
  logic [31:0]   pq_data [$];
  logic [IW-1:0] pq_id   [$];
  logic [31:0]   eq_data [$];
  logic [IW-1:0] eq_id   [$];
  logic          eq_last [$];
  string         eq_tag  [$];
  int            n_run = 0;
  int            n_fail = 0;
  int            id_ctr = 0;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] expect_word(input int op, input logic [31:0] old,
                                              input logic [31:0] opnd);
    case (op)
      2: return old | opnd;
      3: return old & ~opnd;
      4: return old + 32'd1;
      5: return old + 32'hFFFF_FFFF;
      6: return old + opnd;
      7: return old + (~opnd + 32'd1);
      8: return opnd;
      default: return old;
    endcase
  endfunction

  // pull source: decides at the falling edge, the unit takes the word at the next rising edge
  always @(negedge clk) begin
    if (rst_n && pull_req && pq_data.size() > 0 && ($urandom % 4) != 0) begin
      pull_data  = pq_data.pop_front();
      check("R13 pull id", 64'(pull_id), 64'(pq_id.pop_front()));
      pull_valid = 1'b1;
    end else begin
      pull_valid = 1'b0;
      pull_data  = $urandom;
    end
  end

  // push monitor
  always @(negedge clk) begin
    if (rst_n && push_valid) begin
      if (eq_data.size() == 0) begin
        check("R9 unexpected push", {push_data, 28'(push_id), 4'(push_last)}, 64'hX);
      end else begin
        check(eq_tag.pop_front(), {push_data, 28'(push_id), 4'(push_last)},
              {eq_data.pop_front(), 28'(eq_id.pop_front()), 4'(eq_last.pop_front())});
      end
    end
  end

  task automatic send(input int op, input int addr, input int len, input bit ret,
                      input logic [31:0] opnd, input string tag);
    logic [IW-1:0] id;
    logic [31:0]   old;
    id = IW'(id_ctr);
    id_ctr++;
    if (op == 0) begin
      for (int i = 0; i <= len; i++) begin
        eq_data.push_back(ref_mem[(addr + i) % DEPTH]);
        eq_id.push_back(id);
        eq_last.push_back(i == len);
        eq_tag.push_back(tag);
      end
    end else if (op == 1) begin
      for (int i = 0; i <= len; i++) begin
        logic [31:0] w;
        w = $urandom;
        pq_data.push_back(w);
        pq_id.push_back(id);
        ref_mem[(addr + i) % DEPTH] = w;
      end
    end else if (op >= 2 && op <= 8) begin
      old = ref_mem[addr];
      if (op != 4 && op != 5) begin
        pq_data.push_back(opnd);
        pq_id.push_back(id);
      end
      if (ret) begin
        eq_data.push_back(old);
        eq_id.push_back(id);
        eq_last.push_back(1'b1);
        eq_tag.push_back(tag);
      end
      ref_mem[addr] = expect_word(op, old, opnd);
    end
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op    = 4'(op);
    cmd_addr  = AW'(addr);
    cmd_len   = 4'(len);
    cmd_ret   = ret;
    cmd_id    = id;
    while (!cmd_ready) @(negedge clk);
    @(posedge clk);
    #1;
    cmd_valid = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (cmd_ready && eq_data.size() == 0 && pq_data.size() == 0 && !push_valid) break;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_up();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #(20.0 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    void'($urandom(32'h1234_5eed));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 cmd_ready", 64'(cmd_ready), 64'd1);
    check("R1 push_valid", 64'(push_valid), 64'd0);
    check("R1 pull_req", 64'(pull_req), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready after release", 64'(cmd_ready), 64'd1);

    // R3 fill the store with full-word bursts
    for (int b = 0; b < DEPTH / 16; b++) send(1, b * 16, 15, 0, 0, "R3");
    send(0, 0, 15, 0, 0, "R3 readback");
    send(0, 16, 15, 0, 0, "R2 burst 16");
    send(0, 33, 0, 0, 0, "R2 single");

    // R4 wrap across the top
    send(1, DEPTH - 8, 15, 0, 0, "R4");
    send(0, DEPTH - 8, 15, 0, 0, "R4 wrapped read");
    send(0, DEPTH - 1, 1, 0, 0, "R4 top plus one");

    // R5 bit operations
    send(8, 10, 0, 0, 32'hA5A5_0F0F, "R8");
    send(2, 10, 0, 1, 32'h0000_00F0, "R5 set old");
    send(3, 10, 0, 1, 32'hA000_000F, "R5 clear old");
    send(0, 10, 0, 0, 0, "R5 result");

    // R6 increment/decrement wrap
    send(8, 12, 0, 0, 32'h0, "R8");
    send(5, 12, 0, 1, 0, "R6 dec old");
    send(0, 12, 0, 0, 0, "R6 dec wrap");
    send(4, 12, 0, 1, 0, "R6 inc old");
    send(0, 12, 0, 0, 0, "R6 inc wrap");

    // R7 add/subtract wrap
    send(8, 14, 0, 0, 32'hFFFF_FFF0, "R8");
    send(6, 14, 0, 1, 32'h0000_0020, "R7 add old");
    send(0, 14, 0, 0, 0, "R7 add wrap");
    send(7, 14, 0, 1, 32'h0000_0030, "R7 sub old");
    send(0, 14, 0, 0, 0, "R7 sub wrap");

    // R8 swap returns old
    send(8, 15, 0, 1, 32'hDEAD_BEEF, "R8 swap old");
    send(0, 15, 0, 0, 0, "R8 swap result");

    // R10 stall and ordering
    send(4, 5, 0, 0, 0, "R10");
    @(negedge clk);
    check("R10 stalled after atomic", 64'(cmd_ready), 64'd0);
    send(0, 5, 0, 0, 0, "R10 sees update");

    // R11 atomic ignores length
    send(6, 20, 7, 1, 32'h0000_0100, "R11 old");
    send(0, 19, 3, 0, 0, "R11 neighbours");

    // R12 reserved opcodes
    send(12, 30, 5, 1, 0, "R12");
    @(negedge clk);
    check("R12 no pull", 64'(pull_req), 64'd0);
    send(15, 31, 0, 1, 0, "R12");
    send(0, 30, 5, 0, 0, "R12 unchanged");
    drain();
    check("R12 no push pending", 64'(eq_data.size()), 64'd0);
    check("R13 idle pull_req", 64'(pull_req), 64'd0);

    // random traffic
    for (int n = 0; n < 400; n++) begin
      int op;
      int r;
      r = int'($urandom % 20);
      op = (r < 9) ? r : ((r < 14) ? 0 : ((r < 18) ? 1 : 9 + int'($urandom % 7)));
      case (op)
        0: send(op, int'($urandom % DEPTH), int'($urandom % 16), 0, 0, "R2 random");
        1: send(op, int'($urandom % DEPTH), int'($urandom % 16), 0, 0, "R3 random");
        default: send(op, int'($urandom % DEPTH), int'($urandom % 16), 1'($urandom),
                      $urandom, "R9 random");
      endcase
    end
    for (int b = 0; b < DEPTH / 16; b++) send(0, b * 16, 15, 0, 0, "R11 final image");
    drain();
    check("R9 all pushes seen", 64'(eq_data.size()), 64'd0);
    check("R13 all pull words taken", 64'(pq_data.size()), 64'd0);
    finish_up();
  end

endmodule